// File: doc/BRIEF.md
# Transmit Frame Pad and FCS Inserter

This stage sits on the transmit path between a packet source and a MAC output. Bytes arrive one per transfer on a valid/ready stream with start and end markers. Each packet leaves as one frame on a second valid/ready stream with the same markers. Two options apply per frame. The first extends a short packet with zero bytes up to the 64-byte minimum frame. The second computes a CRC-32 frame check sequence over everything sent before it and appends it.

A transmit enable gates only the start of a packet. A frame already in progress always runs to its end. While the enable is low, a waiting start beat is held back by backpressure and is never thrown away. A length ceiling limits the whole outgoing transfer. A packet that would exceed it is cut at the ceiling, its frame is closed normally, and an error flag is raised on the closing byte. Two strobes feed the statistics counters kept elsewhere: one per output byte and one per finished frame.

Top module: `tx_pad_fcs`

## Requirements
- R1: In idle with `cfg_en` low, a start beat (`in_sop`=1) is not accepted (`in_ready`=0) and nothing is emitted. The same beat is accepted and sent once `cfg_en` rises.
- R2: Lowering `cfg_en` after a packet's start beat has been accepted does not shorten or alter that frame.
- R3: With padding on, zero bytes follow the data until data plus pad reach 60 bytes when the FCS is on (64 with FCS), or 64 bytes when the FCS is off. With padding off, no byte is added.
- R4: With the FCS on, the four bytes after data and pad are the complement of a reflected CRC-32. The CRC uses polynomial 0x04C11DB7 with an all-ones start value and covers data and pad. The bytes are sent least significant byte first and are held stable while `out_ready` is low.
- R5: With the FCS off, the frame is the data followed only by any pad.
- R6: A frame never exceeds `cfg_max_len` bytes. A longer packet is cut so that data plus FCS equal the ceiling, the FCS covers the kept bytes, and `out_err` is 1 on the last byte. The rest of that packet is consumed with no output.
- R7: `byte_inc` pulses once for every byte transferred on the output, including pad and FCS bytes.
- R8: Each frame carries exactly one `out_sop`, on its first byte, and one `out_eop`, on its last. `frame_done` pulses exactly once per frame, with that last byte.
- R9: Pad, FCS and ceiling settings are taken at the start beat. Changing them during a frame has no effect on that frame.
- R10: After reset, no output is valid and neither strobe is active.
- R11: A beat without `in_sop` arriving while idle is consumed and discarded, with no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Transmit enable, honoured at packet start only |
| cfg_pad_en | input | 1 | Pad short packets to the minimum frame |
| cfg_crc_en | input | 1 | Append the CRC-32 FCS |
| cfg_max_len | input | LEN_W | Ceiling on the outgoing frame length in bytes |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a frame |
| out_eop | output | 1 | Last byte of a frame |
| out_err | output | 1 | Frame was cut at the ceiling; valid with out_eop |
| byte_inc | output | 1 | One pulse per output byte transferred |
| frame_done | output | 1 | One pulse per completed frame |

## Verification
The assertions assume the following about the inputs:
- Packets are well formed: one start beat, then data, then one end beat.
- `cfg_max_len` is at least 64 whenever padding may apply. This lets the ceiling and the pad target never conflict.
- `in_data` is held stable while a beat waits for `in_ready`.

The stimulus meets these conditions by design. It drives whole packets from a task and holds each beat until it is taken. It uses ceilings of 70 bytes and above, and changes configuration only between beats of an accepted packet or while a start beat waits in idle. Downstream stalls are produced by a pseudo-random `out_ready`, to load the FCS hold rule.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_DRAIN
    } txf_state_e;

    localparam int FCS_BYTES = 4;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
endpackage

// File: rtl/txf_crc8.sv
module txf_crc8
    import txf_pkg::*;
(
    input  logic [31:0] crc_i,
    input  logic [7:0]  data_i,
    output logic [31:0] crc_o
);
    // Eight LSB-first shift steps of the reflected CRC-32.
    always_comb begin
        crc_o = crc_i ^ {24'd0, data_i};
        for (int b = 0; b < 8; b++) begin
            crc_o = crc_o[0] ? ((crc_o >> 1) ^ CRC_POLY_REFL) : (crc_o >> 1);
        end
    end
endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
    import txf_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int MIN_FRAME = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_pad_en,
    input  logic             cfg_crc_en,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_err,
    output logic             byte_inc,
    output logic             frame_done
);
    localparam logic [LEN_W-1:0] TGT_WITH_FCS = LEN_W'(MIN_FRAME - FCS_BYTES);
    localparam logic [LEN_W-1:0] TGT_NO_FCS   = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] FCS_LEN      = LEN_W'(FCS_BYTES);

    typedef struct packed {
        txf_state_e       st;
        logic [LEN_W-1:0] cnt;   // data + pad bytes sent in this frame
        logic [31:0]      crc;
        logic [1:0]       fidx;
        logic             pad;   // settings captured at the start beat
        logic             fcs;
        logic [LEN_W-1:0] lim;
        logic             cut;
    } ctx_t;

    ctx_t q, d;

    logic             idle, open_gate, acc, last_beat, at_lim, need_pad;
    logic             e_pad, e_fcs;
    logic [LEN_W-1:0] e_lim, data_lim, pad_tgt, cnt_n;
    logic [7:0]       crc_din;
    logic [31:0]      crc_base, crc_next, fcs_word;

    txf_crc8 u_crc (
        .crc_i (crc_base),
        .data_i(crc_din),
        .crc_o (crc_next)
    );

    always_comb begin
        d         = q;
        idle      = (q.st == ST_IDLE);
        e_pad     = idle ? cfg_pad_en  : q.pad;
        e_fcs     = idle ? cfg_crc_en  : q.fcs;
        e_lim     = idle ? cfg_max_len : q.lim;
        data_lim  = e_lim - (e_fcs ? FCS_LEN : '0);
        pad_tgt   = e_fcs ? TGT_WITH_FCS : TGT_NO_FCS;
        cnt_n     = (idle ? '0 : q.cnt) + LEN_W'(1);
        crc_base  = idle ? '1 : q.crc;
        crc_din   = in_data;
        fcs_word  = ~q.crc;
        open_gate = 1'b0;
        acc       = 1'b0;
        at_lim    = 1'b0;
        last_beat = 1'b0;
        need_pad  = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        out_err   = 1'b0;

        case (q.st)
            ST_IDLE, ST_DATA: begin
                if (idle && !in_sop) begin
                    in_ready = 1'b1;                 // stray beat: discard
                end else begin
                    open_gate = !idle || cfg_en;
                    out_valid = in_valid && open_gate;
                    in_ready  = out_ready && open_gate;
                    out_data  = in_data;
                    out_sop   = idle;
                    at_lim    = (cnt_n >= data_lim);
                    last_beat = in_eop || at_lim;
                    need_pad  = e_pad && (cnt_n < pad_tgt);
                    out_eop   = last_beat && !need_pad && !e_fcs;
                    out_err   = out_eop && at_lim && !in_eop;
                    acc       = out_valid && out_ready;
                    if (acc) begin
                        d.st   = ST_DATA;
                        d.cnt  = cnt_n;
                        d.crc  = crc_next;
                        d.pad  = e_pad;
                        d.fcs  = e_fcs;
                        d.lim  = e_lim;
                        d.cut  = at_lim && !in_eop;
                        d.fidx = 2'd0;
                        if (last_beat) begin
                            if (need_pad)                  d.st = ST_PAD;
                            else if (e_fcs)                d.st = ST_FCS;
                            else if (at_lim && !in_eop)    d.st = ST_DRAIN;
                            else                           d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_PAD: begin
                crc_din   = 8'h00;
                out_valid = 1'b1;
                out_eop   = (cnt_n == pad_tgt) && !q.fcs;
                if (out_ready) begin
                    d.cnt = cnt_n;
                    d.crc = crc_next;
                    if (cnt_n == pad_tgt) d.st = q.fcs ? ST_FCS : ST_IDLE;
                end
            end
            ST_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs_word[8*q.fidx +: 8];
                out_eop   = (q.fidx == 2'd3);
                out_err   = out_eop && q.cut;
                if (out_ready) begin
                    d.fidx = q.fidx + 2'd1;
                    if (q.fidx == 2'd3) d.st = q.cut ? ST_DRAIN : ST_IDLE;
                end
            end
            ST_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && in_eop) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        byte_inc   = out_valid && out_ready;
        frame_done = byte_inc && out_eop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, crc: '1, fidx: 2'd0,
                   pad: 1'b0, fcs: 1'b0, lim: '0, cut: 1'b0};
        end else begin
            q <= d;
        end
    end

    // R1: a held start beat sees no acceptance and produces no output
    a_r1_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !cfg_en && in_sop) |-> (!in_ready && !out_valid));

    // R2: once a frame has started, a non-final transfer never returns to idle
    a_r2_frame_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && q.st != ST_DRAIN && out_valid && out_ready && !out_eop)
        |=> (q.st != ST_IDLE));

    // R3: padding only when enabled and only below the target length
    a_r3_pad_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PAD) |-> (q.pad && (q.cnt < (q.fcs ? TGT_WITH_FCS : TGT_NO_FCS))));

    // R4: an FCS byte stays put while the sink stalls
    a_r4_fcs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FCS && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5: FCS bytes only in frames captured with the FCS on
    a_r5_fcs_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FCS) |-> q.fcs);

    // R6: the running count never passes the captured ceiling
    a_r6_under_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> (q.cnt <= q.lim));
endmodule

// File: tb/sim_tx_pad_fcs.sv
module sim_tx_pad_fcs;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_en = 1'b1, cfg_pad_en = 1'b0, cfg_crc_en = 1'b0;
    logic [LEN_W-1:0] cfg_max_len = 14'd9250;
    logic             in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             out_ready = 1'b1;
    logic             in_ready, out_valid, out_sop, out_eop, out_err, byte_inc, frame_done;
    logic [7:0]       out_data;

    tx_pad_fcs #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_pad_en(cfg_pad_en),
        .cfg_crc_en(cfg_crc_en), .cfg_max_len(cfg_max_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .byte_inc(byte_inc), .frame_done(frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int byte_cnt = 0, frame_cnt = 0, sop_cnt = 0, eop_cnt = 0;
    bit last_err = 1'b0, stall_on = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        #1;
        if (stall_on) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = lfsr[0] | lfsr[2];
        end else begin
            out_ready = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                got_q.push_back(out_data);
                if (out_sop) sop_cnt++;
                if (out_eop) begin eop_cnt++; last_err = out_err; end
            end
            if (byte_inc)   byte_cnt++;
            if (frame_done) frame_cnt++;
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++) begin
            if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    task automatic build_exp(input int len, input bit pad, input bit crc,
                             input int lim, output bit cut);
        int dl = crc ? lim - 4 : lim;
        int n;
        logic [31:0] c = 32'hFFFF_FFFF;
        cut = (len > dl);
        n = cut ? dl : len;
        exp_q.delete();
        for (int i = 0; i < n; i++) exp_q.push_back(pat(i));
        if (pad && !cut) while (exp_q.size() < (crc ? 60 : 64)) exp_q.push_back(8'h00);
        if (crc) begin
            foreach (exp_q[i]) c = crc_step(c, exp_q[i]);
            c = ~c;
            for (int k = 0; k < 4; k++) exp_q.push_back(c[8*k +: 8]);
        end
    endtask

    task automatic put_beat(input logic [7:0] dat, input bit sop, input bit eop);
        bit taken;
        in_valid = 1'b1; in_data = dat; in_sop = sop; in_eop = eop;
        do begin
            @(negedge clk); taken = in_ready;
            @(posedge clk); #1;
        end while (!taken);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    // act: 0 none, 1 drop enable, 2 flip FCS, 3 flip pad, applied after beat idx
    task automatic run_case(input string tag, input int len, input bit pad, input bit crc,
                            input int lim, input int act, input int idx,
                            input bit hold, input bit stray);
        bit cut;
        int bc0, fc0, sc0, ec0, bad;
        cfg_en = 1'b1; cfg_pad_en = pad; cfg_crc_en = crc; cfg_max_len = LEN_W'(lim);
        got_q.delete();
        build_exp(len, pad, crc, lim, cut);
        bc0 = byte_cnt; fc0 = frame_cnt; sc0 = sop_cnt; ec0 = eop_cnt;
        if (stray) put_beat(8'hAA, 1'b0, 1'b1);
        if (hold) begin
            cfg_en = 1'b0;
            in_valid = 1'b1; in_sop = 1'b1; in_eop = (len == 1); in_data = pat(0);
            bad = 0;
            repeat (20) begin
                @(negedge clk);
                if (in_ready || out_valid) bad++;
            end
            check(bad == 0 && got_q.size() == 0, "R1", "held start beat", bad, 0);
            @(posedge clk); #1;
            cfg_en = 1'b1;
        end
        for (int i = 0; i < len; i++) begin
            put_beat(pat(i), i == 0, i == len - 1);
            if (i == idx) begin
                if (act == 1) cfg_en = 1'b0;
                if (act == 2) cfg_crc_en = !crc;
                if (act == 3) cfg_pad_en = !pad;
            end
        end
        while (frame_cnt < fc0 + 1) @(negedge clk);
        @(posedge clk); #1;
        repeat (3) @(posedge clk);
        #1;
        check(got_q.size() == exp_q.size(), tag, "frame length", got_q.size(), exp_q.size());
        bad = 0;
        foreach (exp_q[i]) if (i >= got_q.size() || got_q[i] !== exp_q[i]) bad++;
        check(bad == 0, tag, "byte mismatches", bad, 0);
        check(last_err == cut, cut ? "R6" : tag, "error flag", last_err, cut);
        check(byte_cnt - bc0 == exp_q.size(), "R7", "byte strobes", byte_cnt - bc0, exp_q.size());
        check(frame_cnt - fc0 == 1 && sop_cnt - sc0 == 1 && eop_cnt - ec0 == 1, "R8",
              "frame/sop/eop per frame", frame_cnt - fc0, 1);
        cfg_en = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!out_valid && !byte_inc && !frame_done, "R10", "outputs after reset",
              out_valid + byte_inc + frame_done, 0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        run_case("R4", 100, 1, 1, 9250, 0, 0, 0, 0);
        run_case("R5", 100, 1, 0, 9250, 0, 0, 0, 0);
        run_case("R3", 10, 1, 1, 9250, 0, 0, 0, 0);
        run_case("R3", 10, 1, 0, 9250, 0, 0, 0, 0);
        run_case("R3", 10, 0, 1, 9250, 0, 0, 0, 0);
        run_case("R6", 100, 1, 1, 80, 0, 0, 0, 0);
        run_case("R6", 100, 0, 0, 70, 0, 0, 0, 0);
        run_case("R1", 20, 1, 1, 9250, 0, 0, 1, 0);
        run_case("R2", 70, 0, 1, 9250, 1, 5, 0, 0);
        run_case("R9", 30, 1, 1, 9250, 2, 3, 0, 0);
        run_case("R9", 30, 1, 0, 9250, 3, 3, 0, 0);
        run_case("R11", 12, 1, 1, 9250, 0, 0, 0, 1);
        stall_on = 1'b1;
        run_case("R4", 50, 1, 1, 9250, 0, 0, 0, 0);
        run_case("R4", 8, 1, 1, 9250, 0, 0, 0, 0);
        stall_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule